// File: doc/BRIEF.md
# Memory ECC Error Injector

This block sits on the write-data path of a memory controller, between the ECC encoder and the DRAM command issue logic. Each write beat carries a 144-bit stored codeword made of two 72-bit halves, a command/address parity bit and the location it targets: channel, DIMM within that channel, rank, bank, page and column. When software has armed the injector and a write targets a location that satisfies the programmed match, the block flips chosen codeword bits, or the parity bit, so that the read-side error handling can be exercised against real stored faults.

Matching is done field by field. Each of the six location fields holds a compare value and its own wildcard flag, and a write hits only when every field is either wildcarded or equal. A section selector picks the lower half, the upper half or both halves to corrupt. A type field chooses data corruption or parity corruption and whether the injection repeats or fires once and disarms itself.

The beat stream uses valid/ready with no storage in the block: `out_valid` follows `in_valid`, `in_ready` follows `out_ready`, and the payload passes through combinationally. A beat stalled by back-pressure shows the same, possibly corrupted, payload every cycle until it is accepted; only an accepted beat (`in_valid` and `out_ready` both high at a clock edge) consumes a one-shot injection. The location fields go on to the controller on their own wires; this block only observes them.

Top module: `ecc_fault_injector`

## Requirements
- R1: After reset every match register reads 0x8000_0000 (wildcard set, value 0), and the mask words, section, type and enable registers read 0.
- R2: Register map on `cfg_addr`: 0 DIMM, 1 rank, 2 channel, 3 bank, 4 page, 5 column (bit 31 wildcard, low bits compare value, truncated to the field width: 2, 2, 2, 4, 16, 10 bits); 6, 7, 8 mask bits 31:0, 63:32, 71:64; 9 section (2 bits); 10 type (3 bits); 11 enable (1 bit). Every register reads back its stored value on `cfg_rdata` in the same cycle.
- R3: Writing any nonzero value to the enable register arms the injector and it reads 1; writing 0 disarms it. While disarmed every beat passes through unchanged.
- R4: Only beats with `in_write` high can hit; read beats always pass through unchanged.
- R5: A write hits when each match field is wildcarded or equals the beat's field; a single differing non-wildcard field prevents the hit.
- R6: Section 1 corrupts codeword bits 71:0, section 2 bits 143:72, section 3 both, section 0 neither.
- R7: With type bit 1 (data error) set and bit 2 clear, a hit XORs the 72-bit mask into each selected half.
- R8: With type bit 2 (parity error) set, a hit inverts `out_par` and leaves the codeword unchanged.
- R9: With type bit 0 (repeat) clear, the first accepted hitting beat clears enable on that clock edge; a hitting beat stalled with `out_ready` low is corrupted but does not disarm.
- R10: With type bit 0 set, every hitting beat is corrupted and enable stays set.
- R11: `out_valid` equals `in_valid` and `in_ready` equals `out_ready` in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 4 | Register index for write and read |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data for `cfg_addr` |
| in_valid | input | 1 | Upstream beat valid |
| in_ready | output | 1 | Upstream beat accepted |
| in_write | input | 1 | Beat is a write |
| in_chan | input | 2 | Target channel |
| in_dimm | input | 2 | Target DIMM within the channel |
| in_rank | input | 2 | Target rank |
| in_bank | input | 4 | Target bank |
| in_page | input | 16 | Target page (row) address |
| in_col | input | 10 | Target column |
| in_par | input | 1 | Command/address parity from upstream |
| in_code | input | 144 | Encoded codeword, two 72-bit halves |
| out_valid | output | 1 | Downstream beat valid |
| out_ready | input | 1 | Downstream ready |
| out_par | output | 1 | Parity, possibly inverted |
| out_code | output | 144 | Codeword, possibly corrupted |

## Verification
A wrong enable bit shows at once: an unarmed injector corrupts nothing, and a one-shot that fails to disarm corrupts the very next hitting write one cycle later, which the enable readback also exposes in that cycle. A wrong wildcard or compare value shows as a clean beat where corruption was expected, or the reverse, on the same beat since the payload path is combinational. Stale section or type state lands the mask in the wrong half or on parity instead of data, visible on `out_code` and `out_par` in the beat's own cycle.

// File: rtl/inj_pkg.sv
package inj_pkg;
  localparam int NFLD = 6;
  localparam int VW   = 16;

  typedef enum logic [3:0] {
    RA_DIMM  = 4'd0,
    RA_RANK  = 4'd1,
    RA_CHAN  = 4'd2,
    RA_BANK  = 4'd3,
    RA_PAGE  = 4'd4,
    RA_COL   = 4'd5,
    RA_MASK0 = 4'd6,
    RA_MASK1 = 4'd7,
    RA_MASK2 = 4'd8,
    RA_SECT  = 4'd9,
    RA_TYPE  = 4'd10,
    RA_EN    = 4'd11
  } reg_addr_e;

  localparam int TY_REPEAT = 0;
  localparam int TY_ECC    = 1;
  localparam int TY_PAR    = 2;
endpackage

// File: rtl/inj_regs.sv
module inj_regs #(
  parameter int HALF_W = 72,
  parameter int NHALF  = 2,
  parameter int unsigned FW [inj_pkg::NFLD] = '{2, 2, 2, 4, 16, 10}
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         we,
  input  logic [3:0]                   addr,
  input  logic [31:0]                  wdata,
  output logic [31:0]                  rdata,
  input  logic                         consume,
  output logic [inj_pkg::NFLD-1:0]     any_q,
  output logic [inj_pkg::VW-1:0]       val_q [inj_pkg::NFLD],
  output logic [HALF_W-1:0]            mask_q,
  output logic [NHALF-1:0]             sect_q,
  output logic [2:0]                   typ_q,
  output logic                         armed_q
);
  import inj_pkg::*;

  function automatic logic [VW-1:0] fmask(int unsigned w);
    return VW'((32'd1 << w) - 32'd1);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      any_q   <= '1;
      mask_q  <= '0;
      sect_q  <= '0;
      typ_q   <= '0;
      armed_q <= 1'b0;
      for (int i = 0; i < NFLD; i++) val_q[i] <= '0;
    end else begin
      if (we) begin
        for (int i = 0; i < NFLD; i++) begin
          if (int'(addr) == i) begin
            any_q[i] <= wdata[31];
            val_q[i] <= wdata[VW-1:0] & fmask(FW[i]);
          end
        end
        for (int b = 0; b < HALF_W; b++) begin
          if (int'(addr) == int'(RA_MASK0) + b / 32) mask_q[b] <= wdata[b % 32];
        end
        if (addr == RA_SECT) sect_q <= wdata[NHALF-1:0];
        if (addr == RA_TYPE) typ_q  <= wdata[2:0];
      end
      if (we && addr == RA_EN) armed_q <= |wdata;
      else if (consume)        armed_q <= 1'b0;
    end
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < NFLD; i++) begin
      if (int'(addr) == i) begin
        rdata[31]     = any_q[i];
        rdata[VW-1:0] = val_q[i];
      end
    end
    for (int b = 0; b < HALF_W; b++) begin
      if (int'(addr) == int'(RA_MASK0) + b / 32) rdata[b % 32] = mask_q[b];
    end
    if (addr == RA_SECT) rdata[NHALF-1:0] = sect_q;
    if (addr == RA_TYPE) rdata[2:0]       = typ_q;
    if (addr == RA_EN)   rdata[0]         = armed_q;
  end
endmodule

// File: rtl/inj_match.sv
module inj_match (
  input  logic [inj_pkg::NFLD-1:0] any_q,
  input  logic [inj_pkg::VW-1:0]   val_q [inj_pkg::NFLD],
  input  logic [inj_pkg::VW-1:0]   req   [inj_pkg::NFLD],
  output logic                     all_hit
);
  import inj_pkg::*;
  logic [NFLD-1:0] fhit;

  for (genvar i = 0; i < NFLD; i++) begin : g_fld
    assign fhit[i] = any_q[i] | (val_q[i] == req[i]);
  end

  assign all_hit = &fhit;
endmodule

// File: rtl/inj_corrupt.sv
module inj_corrupt #(
  parameter int HALF_W = 72,
  parameter int NHALF  = 2,
  localparam int CW    = HALF_W * NHALF
) (
  input  logic [CW-1:0]     code_in,
  input  logic [HALF_W-1:0] mask,
  input  logic [NHALF-1:0]  sel,
  input  logic              apply,
  output logic [CW-1:0]     code_out
);
  for (genvar h = 0; h < NHALF; h++) begin : g_half
    assign code_out[h*HALF_W +: HALF_W] =
      code_in[h*HALF_W +: HALF_W] ^ ({HALF_W{apply & sel[h]}} & mask);
  end
endmodule

// File: rtl/ecc_fault_injector.sv
module ecc_fault_injector #(
  parameter int HALF_W = 72,
  parameter int NHALF  = 2,
  parameter int CHAN_W = 2,
  parameter int DIMM_W = 2,
  parameter int RANK_W = 2,
  parameter int BANK_W = 4,
  parameter int PAGE_W = 16,
  parameter int COL_W  = 10,
  localparam int CW    = HALF_W * NHALF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [3:0]        cfg_addr,
  input  logic [31:0]       cfg_wdata,
  output logic [31:0]       cfg_rdata,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              in_write,
  input  logic [CHAN_W-1:0] in_chan,
  input  logic [DIMM_W-1:0] in_dimm,
  input  logic [RANK_W-1:0] in_rank,
  input  logic [BANK_W-1:0] in_bank,
  input  logic [PAGE_W-1:0] in_page,
  input  logic [COL_W-1:0]  in_col,
  input  logic              in_par,
  input  logic [CW-1:0]     in_code,
  output logic              out_valid,
  input  logic              out_ready,
  output logic              out_par,
  output logic [CW-1:0]     out_code
);
  import inj_pkg::*;

  localparam int unsigned FW [NFLD] = '{DIMM_W, RANK_W, CHAN_W, BANK_W, PAGE_W, COL_W};

  logic [NFLD-1:0]   any_q;
  logic [VW-1:0]     val_q [NFLD];
  logic [VW-1:0]     req   [NFLD];
  logic [HALF_W-1:0] mask_q;
  logic [NHALF-1:0]  sect_q;
  logic [2:0]        typ_q;
  logic              armed_q;
  logic              loc_hit, hit, fire, consume, par_inj, ecc_inj;

  assign req[RA_DIMM] = VW'(in_dimm);
  assign req[RA_RANK] = VW'(in_rank);
  assign req[RA_CHAN] = VW'(in_chan);
  assign req[RA_BANK] = VW'(in_bank);
  assign req[RA_PAGE] = VW'(in_page);
  assign req[RA_COL]  = VW'(in_col);

  inj_regs #(.HALF_W(HALF_W), .NHALF(NHALF), .FW(FW)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .rdata(cfg_rdata), .consume(consume), .any_q(any_q), .val_q(val_q),
    .mask_q(mask_q), .sect_q(sect_q), .typ_q(typ_q), .armed_q(armed_q)
  );

  inj_match u_match (.any_q(any_q), .val_q(val_q), .req(req), .all_hit(loc_hit));

  assign hit     = armed_q & in_valid & in_write & loc_hit;
  assign fire    = hit & out_ready;
  assign consume = fire & ~typ_q[TY_REPEAT];
  assign par_inj = hit & typ_q[TY_PAR];
  assign ecc_inj = hit & typ_q[TY_ECC] & ~typ_q[TY_PAR];

  inj_corrupt #(.HALF_W(HALF_W), .NHALF(NHALF)) u_corrupt (
    .code_in(in_code), .mask(mask_q), .sel(sect_q), .apply(ecc_inj), .code_out(out_code)
  );

  assign out_par   = in_par ^ par_inj;
  assign out_valid = in_valid;
  assign in_ready  = out_ready;
endmodule

// File: rtl/ecc_fault_injector_chk.sv
module ecc_fault_injector_chk #(
  parameter int CW = 144,
  parameter int NHALF = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic             out_valid,
  input logic             out_ready,
  input logic             in_write,
  input logic             in_par,
  input logic             out_par,
  input logic [CW-1:0]    in_code,
  input logic [CW-1:0]    out_code,
  input logic             armed_q,
  input logic [NHALF-1:0] sect_q,
  input logic [2:0]       typ_q
);
  a_r11_stream_follow: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid == in_valid) && (in_ready == out_ready));

  a_r3_disarmed_clean: assert property (@(posedge clk) disable iff (!rst_n)
    !armed_q |-> (out_code == in_code) && (out_par == in_par));

  a_r4_read_clean: assert property (@(posedge clk) disable iff (!rst_n)
    !in_write |-> (out_code == in_code) && (out_par == in_par));

  a_r6_no_section: assert property (@(posedge clk) disable iff (!rst_n)
    (sect_q == '0) |-> (out_code == in_code));

  a_r8_parity_only: assert property (@(posedge clk) disable iff (!rst_n)
    typ_q[2] |-> (out_code == in_code));

  a_r9_one_shot_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && out_ready && !typ_q[0] && (out_par != in_par || out_code != in_code))
      |=> !armed_q);
endmodule

bind ecc_fault_injector ecc_fault_injector_chk #(.CW(CW), .NHALF(NHALF)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .in_write(in_write),
  .in_par(in_par), .out_par(out_par), .in_code(in_code), .out_code(out_code),
  .armed_q(armed_q), .sect_q(sect_q), .typ_q(typ_q)
);

// File: tb/ecc_fault_injector_bench.sv
`timescale 1ns/1ps
module ecc_fault_injector_bench;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         cfg_we = 1'b0;
  logic [3:0]   cfg_addr = '0;
  logic [31:0]  cfg_wdata = '0;
  logic [31:0]  cfg_rdata;
  logic         in_valid = 1'b0, in_ready, in_write = 1'b0;
  logic [1:0]   in_chan = '0, in_dimm = '0, in_rank = '0;
  logic [3:0]   in_bank = '0;
  logic [15:0]  in_page = '0;
  logic [9:0]   in_col = '0;
  logic         in_par = 1'b0, out_valid, out_ready = 1'b1, out_par;
  logic [143:0] in_code = '0, out_code;

  int total = 0, bad = 0;
  bit done = 0;

  localparam logic [71:0]  MASK  = 72'hA5_0000_0000_0000_0301;
  localparam logic [143:0] CODE1 = {72'h12_3456_789A_BCDE_F012, 72'hFE_DCBA_9876_5432_10FE};

  always #2.5 clk = ~clk;

  ecc_fault_injector u_ecc_fault_injector (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .in_valid(in_valid),
    .in_ready(in_ready), .in_write(in_write), .in_chan(in_chan),
    .in_dimm(in_dimm), .in_rank(in_rank), .in_bank(in_bank),
    .in_page(in_page), .in_col(in_col), .in_par(in_par), .in_code(in_code),
    .out_valid(out_valid), .out_ready(out_ready), .out_par(out_par),
    .out_code(out_code)
  );

  function automatic logic [143:0] expect_code(logic [143:0] c, logic [1:0] s);
    logic [143:0] r = c;
    if (s[0]) r[71:0]   = c[71:0]   ^ MASK;
    if (s[1]) r[143:72] = c[143:72] ^ MASK;
    return r;
  endfunction

  task automatic check(string rq, logic [143:0] act, logic [143:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(posedge clk); #1;
    cfg_we = 1'b0;
  endtask

  task automatic rd(logic [3:0] a, logic [31:0] exp, string rq);
    @(negedge clk);
    cfg_addr = a; #1;
    check(rq, 144'(cfg_rdata), 144'(exp));
  endtask

  task automatic beat(logic w, logic [3:0] bank, logic rdy, logic par, logic [143:0] c);
    @(negedge clk);
    in_valid = 1'b1; in_write = w; in_bank = bank; out_ready = rdy;
    in_par = par; in_code = c;
    in_chan = 2'd1; in_dimm = 2'd2; in_rank = 2'd1; in_page = 16'h1234; in_col = 10'h2A;
    #1;
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 1'b0; in_write = 1'b0; out_ready = 1'b1;
  endtask

  task automatic t_reset();
    for (int i = 0; i < 6; i++) rd(4'(i), 32'h8000_0000, "R1");
    for (int i = 6; i < 12; i++) rd(4'(i), 32'h0, "R1");
  endtask

  task automatic t_readback();
    wr(4'd0, 32'h0000_0007); rd(4'd0, 32'h0000_0003, "R2");
    wr(4'd4, 32'h8001_BEEF); rd(4'd4, 32'h8000_BEEF, "R2");
    wr(4'd8, 32'hFFFF_FFFF); rd(4'd8, 32'h0000_00FF, "R2");
    wr(4'd10, 32'hFFFF_FFFF); rd(4'd10, 32'h7, "R2");
    wr(4'd0, 32'h8000_0000); wr(4'd4, 32'h8000_0000);
    wr(4'd6, MASK[31:0]); wr(4'd7, MASK[63:32]); wr(4'd8, 32'(MASK[71:64]));
    rd(4'd7, MASK[63:32], "R2");
  endtask

  task automatic t_disarmed();
    wr(4'd9, 32'd3); wr(4'd10, 32'd3);
    beat(1'b1, 4'd0, 1'b0, 1'b0, CODE1);
    check("R3", out_code, CODE1);
    check("R11", {out_valid, in_ready}, 2'b10);
    idle();
  endtask

  task automatic t_one_shot();
    wr(4'd9, 32'd1); wr(4'd10, 32'd2); wr(4'd11, 32'h100);
    rd(4'd11, 32'd1, "R3");
    beat(1'b1, 4'd7, 1'b0, 1'b0, CODE1);
    check("R7", out_code, expect_code(CODE1, 2'b01));
    @(posedge clk); #1;
    rd(4'd11, 32'd1, "R9");
    beat(1'b1, 4'd7, 1'b1, 1'b0, CODE1);
    check("R9", out_code, expect_code(CODE1, 2'b01));
    check("R11", {out_valid, in_ready}, 2'b11);
    @(posedge clk); #1;
    rd(4'd11, 32'd0, "R9");
    beat(1'b1, 4'd7, 1'b1, 1'b0, CODE1);
    check("R9", out_code, CODE1);
    idle();
  endtask

  task automatic t_sections_repeat();
    wr(4'd10, 32'd3);
    for (int s = 0; s < 4; s++) begin
      wr(4'd9, 32'(s)); wr(4'd11, 32'd1);
      beat(1'b1, 4'd2, 1'b1, 1'b0, CODE1);
      check("R6", out_code, expect_code(CODE1, 2'(s)));
      @(posedge clk); #1;
      beat(1'b1, 4'd2, 1'b1, 1'b0, ~CODE1);
      check("R10", out_code, expect_code(~CODE1, 2'(s)));
      idle();
      rd(4'd11, 32'd1, "R10");
    end
    wr(4'd11, 32'd0);
    beat(1'b1, 4'd2, 1'b1, 1'b0, CODE1);
    check("R3", out_code, CODE1);
    idle();
  endtask

  task automatic t_match();
    wr(4'd9, 32'd2); wr(4'd10, 32'd3); wr(4'd3, 32'h5); wr(4'd11, 32'd1);
    beat(1'b1, 4'd4, 1'b1, 1'b0, CODE1);
    check("R5", out_code, CODE1);
    beat(1'b1, 4'd5, 1'b1, 1'b0, CODE1);
    check("R5", out_code, expect_code(CODE1, 2'b10));
    beat(1'b0, 4'd5, 1'b1, 1'b0, CODE1);
    check("R4", out_code, CODE1);
    idle();
    wr(4'd2, 32'h2);
    beat(1'b1, 4'd5, 1'b1, 1'b0, CODE1);
    check("R5", out_code, CODE1);
    idle();
    wr(4'd2, 32'h8000_0000); wr(4'd3, 32'h8000_0000); wr(4'd11, 32'd0);
  endtask

  task automatic t_parity();
    wr(4'd9, 32'd3); wr(4'd10, 32'd6); wr(4'd11, 32'd1);
    beat(1'b1, 4'd1, 1'b0, 1'b0, CODE1);
    check("R8", {143'd0, out_par}, 144'd1);
    check("R8", out_code, CODE1);
    beat(1'b0, 4'd1, 1'b1, 1'b1, CODE1);
    check("R4", {143'd0, out_par}, 144'd1);
    beat(1'b1, 4'd1, 1'b1, 1'b1, CODE1);
    check("R8", {143'd0, out_par}, 144'd0);
    @(posedge clk); #1;
    rd(4'd11, 32'd0, "R9");
    idle();
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_readback();
    t_disarmed();
    t_one_shot();
    t_sections_repeat();
    t_match();
    t_parity();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule